// File: doc/BRIEF.md
# Clocked Serial I/O Shift Unit

This block is an eight-bit synchronous serial port. A bus write loads the shift register and starts a transfer. For each transfer clock the unit drives one bit on its transmit output and takes one bit from its receive input. Bits go out least-significant first. When the transfer ends, the received byte sits in the same register and can be read through `rd_data`.

The transfer clock comes from one of two sources. The internal source divides the system clock by a programmable amount, and each half period lasts `div_val+1` system cycles. The external source is a pin that passes through a synchronizer, and its edges are detected in the system clock domain. The receive pin also passes through a two-flop synchronizer.

At the end of a transfer the unit raises a sticky interrupt flag. What happens next depends on the clock source. With the internal clock, the clock stops at high and the transmit output is released. With the external clock, the transmit output stays driven and any further edges are ignored. An optional ready output goes low on a write and returns high on the first falling edge of the transfer clock.

Top module: `sio_shift_unit`

## Requirements
- R1: After reset, `irq_o`=0, `rdy_o`=1, `tx_oe_o`=0, `sclk_o`=1 and `rd_data`=0.
- R2: A write (`wr_en`=1) loads `wr_data`, sets `tx_oe_o` and starts a transfer. With the internal clock, `irq_o` is 1 exactly 16*(`div_val`+1) system cycles after the write edge.
- R3: `tx_o` carries bit k of the written byte (k = 0..7) from the k-th falling edge of the transfer clock until the next falling edge, so the byte goes out least-significant bit first.
- R4: On each rising edge of the transfer clock the synchronized receive bit enters bit 7 and the register shifts right. After eight rising edges, bit k of `rd_data` is the bit received at rising edge k.
- R5: When a write occurs with `rdy_en`=1, `rdy_o` is 0 in the following cycle and returns to 1 after the first falling transfer-clock edge. When `rdy_en`=0, `rdy_o` stays 1.
- R6: With the internal clock (`use_ext_clk`=0), `sclk_o` idles at 1, first falls half a period after the write, and is 1 again after the transfer. `tx_oe_o` is 0 once the transfer completes.
- R7: With the external clock (`use_ext_clk`=1), `ext_sclk_i` edges drive the transfer. After completion `tx_oe_o` stays 1, and further edges change neither `rd_data` nor `irq_o`.
- R8: `irq_o` stays 1 until `irq_clr` is pulsed, and then reads 0.
- R9: A write during an active transfer restarts it. Completion timing (R2) counts from the later write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Shift register write strobe |
| wr_data | input | 8 | Byte to transmit |
| rd_data | output | 8 | Shift register contents (received byte) |
| use_ext_clk | input | 1 | 1 = external transfer clock, 0 = internal divider |
| rdy_en | input | 1 | Enable the ready handshake output |
| div_val | input | DIV_W | Internal half-period length minus one, in system cycles |
| irq_clr | input | 1 | Clears the interrupt flag |
| ext_sclk_i | input | 1 | External transfer clock |
| rx_i | input | 1 | Serial receive input |
| sclk_o | output | 1 | Internal transfer clock output |
| tx_o | output | 1 | Serial transmit data |
| tx_oe_o | output | 1 | Transmit driver enable |
| rdy_o | output | 1 | Ready handshake, low while armed |
| irq_o | output | 1 | Transfer-complete interrupt flag |

## Verification
The hardest state to reach from the ports is a completed external-clock transfer that keeps receiving clock edges. To get there, the bench plays the role of the external master and toggles the clock pin for several extra periods after the eighth rising edge. It then checks that the received byte and the driven transmit output did not change. A second hard case is the restart in the middle of a transfer. The bench writes again partway through and times completion from the second write. To receive while in internal-clock mode, the bench acts as a slave that follows `sclk_o`.

// File: rtl/sio_shift_unit.sv
module sio_shift_unit #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              use_ext_clk,
  input  logic              rdy_en,
  input  logic [DIV_W-1:0]  div_val,
  input  logic              irq_clr,
  input  logic              ext_sclk_i,
  input  logic              rx_i,
  output logic              sclk_o,
  output logic              tx_o,
  output logic              tx_oe_o,
  output logic              rdy_o,
  output logic              irq_o
);

  logic [2:0]        ext_sync;
  logic [1:0]        rx_sync;
  logic [DATA_W-1:0] sr;
  logic [CNT_W-1:0]  bit_cnt;
  logic [DIV_W-1:0]  div_cnt;
  logic              active, sclk_int, tx_q, rdy_q, irq_q, oe_q;

  wire ext_fall = ext_sync[2] & ~ext_sync[1];
  wire ext_rise = ~ext_sync[2] & ext_sync[1];
  wire tick_int = active & ~use_ext_clk & (div_cnt == div_val);
  wire fall_ev  = active & (use_ext_clk ? ext_fall : (tick_int & sclk_int));
  wire rise_ev  = active & (use_ext_clk ? ext_rise : (tick_int & ~sclk_int));
  wire last_bit = (bit_cnt == '0);
  wire done_ev  = rise_ev & last_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_sync <= '1;
      rx_sync  <= '0;
    end else begin
      ext_sync <= {ext_sync[1:0], ext_sclk_i};
      rx_sync  <= {rx_sync[0], rx_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr       <= '0;
      bit_cnt  <= '0;
      div_cnt  <= '0;
      active   <= 1'b0;
      sclk_int <= 1'b1;
      tx_q     <= 1'b0;
      rdy_q    <= 1'b1;
      oe_q     <= 1'b0;
    end else if (wr_en) begin
      sr       <= wr_data;
      bit_cnt  <= CNT_W'(DATA_W - 1);
      div_cnt  <= '0;
      active   <= 1'b1;
      sclk_int <= 1'b1;
      oe_q     <= 1'b1;
      if (rdy_en) rdy_q <= 1'b0;
    end else begin
      if (active && !use_ext_clk)
        div_cnt <= tick_int ? '0 : div_cnt + DIV_W'(1);
      if (tick_int) sclk_int <= ~sclk_int;
      if (fall_ev) begin
        tx_q  <= sr[0];
        rdy_q <= 1'b1;
      end
      if (rise_ev) begin
        sr <= {rx_sync[1], sr[DATA_W-1:1]};
        if (last_bit) begin
          active   <= 1'b0;
          sclk_int <= 1'b1;
          if (!use_ext_clk) oe_q <= 1'b0;
        end else begin
          bit_cnt <= bit_cnt - CNT_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       irq_q <= 1'b0;
    else if (done_ev) irq_q <= 1'b1;
    else if (irq_clr) irq_q <= 1'b0;
  end

  assign rd_data = sr;
  assign sclk_o  = sclk_int;
  assign tx_o    = tx_q;
  assign tx_oe_o = oe_q;
  assign rdy_o   = rdy_q;
  assign irq_o   = irq_q;

endmodule

// File: rtl/sio_shift_unit_chk.sv
module sio_shift_unit_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_en,
  input logic rdy_en,
  input logic use_ext_clk,
  input logic irq_clr,
  input logic irq_o,
  input logic rdy_o,
  input logic sclk_o,
  input logic tx_oe_o,
  input logic active
);

  p_oe_on_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> tx_oe_o);

  p_irq_when_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> !active);

  p_rdy_low_after_wr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rdy_en) |=> !rdy_o);

  p_rdy_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_o && !(wr_en && rdy_en)) |=> rdy_o);

  p_sclk_idle_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> sclk_o);

  p_ext_oe_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (use_ext_clk && tx_oe_o) |=> tx_oe_o);

  p_irq_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !irq_clr) |=> irq_o);

endmodule

bind sio_shift_unit sio_shift_unit_chk chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rdy_en(rdy_en),
  .use_ext_clk(use_ext_clk), .irq_clr(irq_clr), .irq_o(irq_o),
  .rdy_o(rdy_o), .sclk_o(sclk_o), .tx_oe_o(tx_oe_o), .active(active)
);

// File: tb/sio_shift_unit_tb_top.sv
module sio_shift_unit_tb_top;
  localparam int PER = 4;
  localparam int NV  = 6;
  // {ext, div[7:0], tx[7:0], rx[7:0]}
  localparam logic [24:0] VEC [NV] = '{
    {1'b0, 8'd2, 8'hA5, 8'h3C},
    {1'b0, 8'd3, 8'h01, 8'hFE},
    {1'b0, 8'd5, 8'h80, 8'h81},
    {1'b1, 8'd0, 8'h5A, 8'hC3},
    {1'b1, 8'd0, 8'hFF, 8'h00},
    {1'b0, 8'd2, 8'h00, 8'hFF}
  };

  logic clk = 0, rst_n = 0, wr_en = 0, use_ext_clk = 0, rdy_en = 0;
  logic irq_clr = 0, ext_sclk_i = 1, rx_i = 0;
  logic [7:0] wr_data = 0, div_val = 2;
  logic [7:0] rd_data;
  logic sclk_o, tx_o, tx_oe_o, rdy_o, irq_o;
  int errs = 0, checks = 0;

  always #(PER/2) clk = ~clk;

  sio_shift_unit dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .use_ext_clk(use_ext_clk), .rdy_en(rdy_en), .div_val(div_val), .irq_clr(irq_clr),
    .ext_sclk_i(ext_sclk_i), .rx_i(rx_i), .sclk_o(sclk_o), .tx_o(tx_o),
    .tx_oe_o(tx_oe_o), .rdy_o(rdy_o), .irq_o(irq_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] d);
    @(negedge clk); wr_data = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic clear_irq();
    @(negedge clk); irq_clr = 1;
    @(negedge clk); irq_clr = 0;
  endtask

  // internal-clock transfer, bench acts as slave following sclk_o
  task automatic run_int(input logic [7:0] div, input logic [7:0] txb, input logic [7:0] rxb,
                         input bit ren, output int cyc, output logic [7:0] got);
    logic prev;
    int nf, nr;
    bit rdy_ok;
    use_ext_clk = 0; div_val = div; rdy_en = ren; rx_i = rxb[0];
    got = 0; nf = 0; nr = 0; cyc = 0; rdy_ok = 1;
    do_write(txb);
    chk(rdy_o == !ren, "R5 ready after write", rdy_o, !ren);
    prev = sclk_o;
    while (!irq_o && cyc < 5000) begin
      @(negedge clk); cyc++;
      if (prev && !sclk_o) begin
        if (nf < 8) rx_i = rxb[nf];
        nf++;
        if (!rdy_o) rdy_ok = 0;
      end
      if (!prev && sclk_o) begin
        if (nr < 8) got[nr] = tx_o;
        nr++;
      end
      prev = sclk_o;
    end
    chk(rdy_ok, "R5 ready high after first fall", rdy_ok, 1);
    chk(nf == 8, "R6 falling edge count", nf, 8);
  endtask

  initial begin
    int cyc;
    logic [7:0] got, keep;
    #(PER*200000);
    errs++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int cyc;
    logic [7:0] got, keep;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(irq_o == 0 && rdy_o == 1 && tx_oe_o == 0 && sclk_o == 1 && rd_data == 0,
        "R1 reset state", {irq_o, rdy_o, tx_oe_o, sclk_o, rd_data}, 12'h0_5_00 >> 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      logic ext; logic [7:0] dv, tb, rb;
      {ext, dv, tb, rb} = VEC[v];
      clear_irq();
      if (!ext) begin
        run_int(dv, tb, rb, v[0], cyc, got);
        chk(cyc == 16 * (dv + 1), "R2 completion time", cyc, 16 * (dv + 1));
        chk(got == tb, "R3 lsb-first transmit", got, tb);
        chk(rd_data == rb, "R4 received byte", rd_data, rb);
        repeat (10) @(negedge clk);
        chk(sclk_o == 1 && tx_oe_o == 0, "R6 idle high and released", {sclk_o, tx_oe_o}, 2'b10);
      end else begin
        bit rdy_ok;
        use_ext_clk = 1; rdy_en = 1; ext_sclk_i = 1; got = 0; rdy_ok = 1;
        do_write(tb);
        chk(rdy_o == 0, "R5 ready low after write", rdy_o, 0);
        for (int i = 0; i < 8; i++) begin
          ext_sclk_i = 0; rx_i = rb[i];
          repeat (4) @(negedge clk);
          got[i] = tx_o;
          if (!rdy_o) rdy_ok = 0;
          ext_sclk_i = 1;
          repeat (4) @(negedge clk);
        end
        chk(rdy_ok, "R5 ready high after first fall", rdy_ok, 1);
        chk(irq_o == 1, "R7 irq after external transfer", irq_o, 1);
        chk(got == tb, "R3 lsb-first transmit external", got, tb);
        chk(rd_data == rb, "R4 received byte external", rd_data, rb);
        keep = rd_data;
        for (int i = 0; i < 3; i++) begin
          ext_sclk_i = 0; rx_i = ~rx_i; repeat (4) @(negedge clk);
          ext_sclk_i = 1; repeat (4) @(negedge clk);
        end
        chk(rd_data == keep && tx_oe_o == 1, "R7 extra edges ignored, output driven",
            {tx_oe_o, rd_data}, {1'b1, keep});
        clear_irq();
        chk(irq_o == 0, "R7 no new irq from extra edges", irq_o, 0);
      end
    end

    // R5: handshake disabled keeps ready high
    clear_irq();
    use_ext_clk = 0; rdy_en = 0; div_val = 2;
    do_write(8'h11);
    chk(rdy_o == 1, "R5 ready stays high when disabled", rdy_o, 1);
    while (!irq_o) @(negedge clk);

    // R8 sticky irq
    repeat (12) @(negedge clk);
    chk(irq_o == 1, "R8 irq held", irq_o, 1);
    clear_irq();
    chk(irq_o == 0, "R8 irq cleared", irq_o, 0);

    // R9 restart mid-transfer
    div_val = 2; rdy_en = 0;
    do_write(8'h33);
    repeat (20) @(negedge clk);
    chk(irq_o == 0, "R9 no irq mid-transfer", irq_o, 0);
    do_write(8'hC4);
    cyc = 0;
    while (!irq_o && cyc < 5000) begin @(negedge clk); cyc++; end
    chk(cyc == 48, "R9 restart completion time", cyc, 48);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule